// File: doc/BRIEF.md
# I2C Master Read Controller

This block is an I2C master that fetches bytes from a slave. A start pulse makes it issue a START condition and send a 7-bit slave address followed by a read direction bit. It then clocks in data bytes, most significant bit first, and raises a ready flag (also routed to an interrupt line) once the eighth bit of each byte is in. Software reads the data register and clears the flag. While an unread byte blocks progress, the controller holds SCL low, which pauses the slave.

Software ends the transfer by setting a stop-request control bit. The controller latches that bit at the start of each data byte. The byte that begins with the request latched is the final byte: the master answers it with a NACK and then drives a STOP condition. A request written in the middle of a byte therefore takes effect on the byte after it. A single-buffer control bit, written while the bus is idle, sets whether one or two bytes may be in flight. In single-buffer mode the bus pauses after every byte until that byte is cleared. In double-buffer mode the next byte is shifted in while the previous one waits unread. Both pins are open drain and are modelled as drive-low enables. The high and low phases of SCL each last `div` system clocks.

Top module: `i2c_rd_master`

## Requirements
- R1: After reset, SCL and SDA are released (both drive enables 0), `rx_ready` is 0 and `busy` is 0.
- R2: A `start` pulse while idle gives exactly one START condition: one cycle later `busy` is 1, SDA is driven low and SCL is still released.
- R3: The first byte on the bus is the 7-bit address, MSB first, followed by a released SDA bit (read = 1).
- R4: Apart from START and STOP, SDA changes only while SCL is low.
- R5: Data bits are sampled at SCL rising edges, MSB first, and `rx_data` holds the received byte unchanged for as long as `rx_ready` stays set.
- R6: `rx_ready` rises after the falling edge of a byte's eighth SCL clock, before its ninth clock, and only while SCL is held low. `irq` follows it.
- R7: `rx_ready` stays set until `rdy_clr`. In single-buffer mode (control bit `ctl_single` = 1), SCL stays low after each byte until the flag is cleared.
- R8: In double-buffer mode (`ctl_single` = 0) the next byte is shifted in while the previous byte is unread. SCL is then held low after that byte's eighth clock, and `rx_data` keeps the older byte until it is cleared.
- R9: On the ninth clock of every byte except the last, the master drives SDA low (ACK).
- R10: The stop request (`ctl_stop` = 1) is latched at the start of each data byte. That byte gets a NACK (SDA released on the ninth clock) and is the last byte. A request written in the middle of a byte applies to the next byte.
- R11: The transfer ends with a STOP (SDA rising while SCL is high). `busy` then falls with both lines released.
- R12: If the slave does not acknowledge the address, the master issues STOP without clocking any data, and `rx_ready` stays 0.
- R13: Each SCL high phase and each SCL low phase between bits lasts `div` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div | input | DIV_W | SCL half-period in clock cycles (values below 2 act as 2) |
| start | input | 1 | Pulse to begin a read transfer while idle |
| slave_addr | input | 7 | Address of the slave to read from |
| ctl_we | input | 1 | Control write strobe |
| ctl_stop | input | 1 | Stop-request bit written with `ctl_we` |
| ctl_single | input | 1 | Single-buffer bit written with `ctl_we` (taken only while idle) |
| rdy_clr | input | 1 | Clears the receive-ready flag |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rx_data | output | 8 | Received data register |
| rx_ready | output | 1 | Receive-ready flag |
| irq | output | 1 | Interrupt request, set with the ready flag |
| busy | output | 1 | High from START until the bus is released after STOP |

## Verification
A behavioural slave on the bus returns known bytes for the matching address. Transfers of one, two and three bytes are run in both buffer modes with data values such as all zeros, all ones, alternating bits and single set bits at either end. These patterns separate bit-order and shift-alignment faults from faults in the buffering path. Single-buffer runs expose a stall that is missing after a byte, and double-buffer runs with a long delay before clearing expose a lost or overwritten byte. A stop request armed mid-byte tells a sample point at the start of the byte apart from one at the end. An unanswered address checks the abort path. Separate measurements of SCL phase length test the divider.

// File: rtl/i2c_rd_master.sv
module i2c_rd_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             start,
  input  logic [6:0]       slave_addr,
  input  logic             ctl_we,
  input  logic             ctl_stop,
  input  logic             ctl_single,
  input  logic             rdy_clr,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             irq,
  output logic             busy
);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_LO, S_HI, S_STALL, S_STOP_LO, S_STOP_HI, S_STOP_END
  } st_t;

  st_t st, nst;
  logic [DIV_W-1:0] dcnt, dlim;
  logic [3:0] bitn;
  logic [7:0] shreg;
  logic [6:0] addr_q;
  logic dphase, last, pend, stop_q, single_q, ack_bad;
  logic tick, want_low, load, byte_end;

  assign dlim     = (div < DIV_W'(2)) ? DIV_W'(2) : div;
  assign tick     = (dcnt == dlim - DIV_W'(1));
  assign load     = pend && !rx_ready;
  assign byte_end = (st == S_HI) && tick && dphase && (bitn == 4'd7);

  assign scl_oe = (st == S_LO) || (st == S_STALL) || (st == S_STOP_LO);
  assign busy   = (st != S_IDLE);
  assign irq    = rx_ready;

  always_comb begin
    if (!dphase)
      want_low = (bitn < 4'd7) ? !addr_q[3'd6 - bitn[2:0]] : 1'b0;
    else
      want_low = (bitn == 4'd8) ? !last : 1'b0;
  end

  always_comb begin
    nst = st;
    case (st)
      S_IDLE:     if (start) nst = S_START;
      S_START:    if (tick) nst = S_LO;
      S_LO:       if (tick) nst = S_HI;
      S_HI: if (tick) begin
        if (bitn == 4'd8)
          nst = (dphase ? last : ack_bad) ? S_STOP_LO : S_LO;
        else if (dphase && bitn == 4'd7)
          nst = S_STALL;
        else
          nst = S_LO;
      end
      S_STALL:    if (!pend && (!single_q || !rx_ready)) nst = S_LO;
      S_STOP_LO:  if (tick) nst = S_STOP_HI;
      S_STOP_HI:  if (tick) nst = S_STOP_END;
      S_STOP_END: if (tick) nst = S_IDLE;
      default:    nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      dcnt     <= '0;
      bitn     <= '0;
      shreg    <= '0;
      addr_q   <= '0;
      dphase   <= 1'b0;
      last     <= 1'b0;
      pend     <= 1'b0;
      stop_q   <= 1'b0;
      single_q <= 1'b0;
      ack_bad  <= 1'b0;
      sda_oe   <= 1'b0;
      rx_data  <= '0;
      rx_ready <= 1'b0;
    end else begin
      st   <= nst;
      dcnt <= (tick || nst != st) ? '0 : dcnt + DIV_W'(1);

      if (st == S_IDLE && start) begin
        addr_q <= slave_addr;
        bitn   <= '0;
        dphase <= 1'b0;
        sda_oe <= 1'b1;
      end

      if (st == S_LO || st == S_STALL) sda_oe <= want_low;
      if (st == S_STOP_LO) sda_oe <= 1'b1;
      if (st == S_STOP_HI && tick) sda_oe <= 1'b0;

      if (st == S_LO && tick) begin
        if (dphase && bitn < 4'd8) shreg <= {shreg[6:0], sda_in};
        if (!dphase && bitn == 4'd8) ack_bad <= sda_in;
      end

      if (st == S_HI && tick) begin
        if (bitn == 4'd8) begin
          bitn   <= '0;
          dphase <= 1'b1;
          last   <= stop_q;
        end else begin
          bitn <= bitn + 4'd1;
        end
      end

      if (byte_end) pend <= 1'b1;
      else if (load) pend <= 1'b0;

      if (load) begin
        rx_data  <= shreg;
        rx_ready <= 1'b1;
      end else if (rdy_clr) begin
        rx_ready <= 1'b0;
      end

      if (ctl_we) stop_q <= ctl_stop;
      else if (st == S_STOP_END && tick) stop_q <= 1'b0;

      if (ctl_we && !busy) single_q <= ctl_single;
    end
  end

endmodule

// File: rtl/i2c_rd_master_chk.sv
module i2c_rd_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       rdy_clr
);

  p_start_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sda_oe && !scl_oe));

  // R4: while SCL stays high inside a transfer, SDA is never pulled low
  p_sda_quiet_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !scl_oe && $past(!scl_oe)) |-> !$rose(sda_oe));

  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && $past(rx_ready)) |-> $stable(rx_data));

  p_ready_low_scl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> scl_oe);

  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rdy_clr) |=> rx_ready);

  p_release_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!scl_oe && !sda_oe));

endmodule

bind i2c_rd_master i2c_rd_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .rx_ready (rx_ready),
  .rx_data  (rx_data),
  .rdy_clr  (rdy_clr)
);

// File: tb/i2c_rd_master_tb.sv
module i2c_rd_master_tb;

  localparam int       DIV   = 6;
  localparam logic [6:0] SLV = 7'h3C;
  localparam int       NVEC  = 6;
  localparam int       LIMIT = 150000;

  // {addr[33:27], single[26], nbytes[25:24], b0[23:16], b1[15:8], b2[7:0]}
  localparam logic [33:0] VEC [NVEC] = '{
    {SLV, 1'b1, 2'd1, 8'hA5, 8'h00, 8'h00},
    {SLV, 1'b1, 2'd3, 8'h80, 8'h01, 8'hFF},
    {SLV, 1'b0, 2'd2, 8'h5A, 8'hC3, 8'h00},
    {SLV, 1'b0, 2'd3, 8'h00, 8'h7E, 8'h81},
    {SLV, 1'b1, 2'd2, 8'h96, 8'h69, 8'h00},
    {SLV, 1'b0, 2'd1, 8'hF0, 8'h00, 8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic start = 0, ctl_we = 0, ctl_stop = 0, ctl_single = 0, rdy_clr = 0;
  logic [6:0] slave_addr = SLV;
  logic scl_oe, sda_oe, rx_ready, irq, busy;
  logic [7:0] rx_data;
  logic s_drv = 0;
  wire  scl_line = !scl_oe;
  wire  sda_line = !(sda_oe || s_drv);

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] s_bytes [4];
  logic       s_acks  [4];
  logic [7:0] s_addr_got = '0;
  int s_cnt = 0, starts = 0, stops = 0;
  int run_len = 0, last_hi = 0, last_lo = 0;
  logic prev_scl = 1, prev_sda = 1;

  always #5 clk = ~clk;

  i2c_rd_master #(.DIV_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .div(8'(DIV)), .start(start),
    .slave_addr(slave_addr), .ctl_we(ctl_we), .ctl_stop(ctl_stop),
    .ctl_single(ctl_single), .rdy_clr(rdy_clr), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_data(rx_data),
    .rx_ready(rx_ready), .irq(irq), .busy(busy)
  );

  // bus monitor: START/STOP events and SCL phase lengths
  always @(negedge clk) begin
    if (prev_scl && scl_line && prev_sda != sda_line) begin
      if (!sda_line) starts++;
      else stops++;
    end
    if (scl_line == prev_scl) run_len++;
    else begin
      if (prev_scl) last_hi = run_len;
      else last_lo = run_len;
      run_len = 1;
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  // behavioural slave transmitter
  initial begin
    forever begin
      @(negedge sda_line);
      if (scl_line) begin
        s_cnt = 0;
        for (int i = 0; i < 8; i++) begin
          @(posedge scl_line);
          s_addr_got = {s_addr_got[6:0], sda_line};
        end
        @(negedge scl_line);
        if (s_addr_got == {SLV, 1'b1}) begin
          s_drv = 1;
          @(negedge scl_line);
          s_drv = 0;
          for (bit done = 0; !done; ) begin
            for (int b = 0; b < 8; b++) begin
              s_drv = !s_bytes[s_cnt % 4][7-b];
              @(negedge scl_line);
            end
            s_drv = 0;
            @(posedge scl_line);
            s_acks[s_cnt % 4] = sda_line;
            done = sda_line;
            s_cnt++;
            @(negedge scl_line);
          end
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic stp, input logic sgl);
    @(negedge clk); ctl_we = 1; ctl_stop = stp; ctl_single = sgl;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic pulse_start();
    starts = 0; stops = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic clr_ready();
    @(negedge clk); rdy_clr = 1;
    @(negedge clk); rdy_clr = 0;
  endtask

  task automatic wait_ready();
    while (!rx_ready) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic finish_report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got %0d cycles expected completion", LIMIT);
    finish_report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 rx_ready", rx_ready, 0);
    chk("R1 busy", busy, 0);

    // table of transfers
    for (int v = 0; v < NVEC; v++) begin
      logic [6:0] va = VEC[v][33:27];
      logic       vs = VEC[v][26];
      int         n  = int'(VEC[v][25:24]);
      s_bytes[0] = VEC[v][23:16];
      s_bytes[1] = VEC[v][15:8];
      s_bytes[2] = VEC[v][7:0];
      slave_addr = va;
      wr_ctl(n == 1, vs);
      pulse_start();
      chk("R2 sda low at start", sda_oe, 1);
      chk("R2 scl high at start", scl_oe, 0);
      for (int k = 0; k < n; k++) begin
        wait_ready();
        chk("R5 rx_data", rx_data, s_bytes[k]);
        chk("R6 ready before ninth clock", s_cnt, k);
        chk("R6 irq", irq, 1);
        if (vs) begin
          repeat (3 * DIV) @(negedge clk);
          chk("R7 scl held low", scl_oe, 1);
          chk("R7 no ninth clock", s_cnt, k);
        end
        if (k == n - 2) wr_ctl(1'b1, vs);
        clr_ready();
      end
      wait_idle();
      chk("R3 address byte", s_addr_got, {va, 1'b1});
      chk("R10 byte count", s_cnt, n);
      for (int k = 0; k < n; k++) begin
        if (k < n - 1) chk("R9 ack low", s_acks[k], 0);
        else chk("R10 nack on last", s_acks[k], 1);
      end
      chk("R2 one start", starts, 1);
      chk("R11 one stop", stops, 1);
      chk("R11 lines released", {scl_line, sda_line}, 2'b11);
    end

    // divider phase lengths
    s_bytes[0] = 8'h3C;
    slave_addr = SLV;
    wr_ctl(1'b1, 1'b1);
    pulse_start();
    repeat (3) @(posedge scl_line);
    @(negedge scl_line);
    @(negedge clk);
    chk("R13 high phase", last_hi, DIV);
    chk("R13 low phase", last_lo, DIV);
    wait_ready();
    chk("R5 rx_data", rx_data, 8'h3C);
    clr_ready();
    wait_idle();

    // double buffer: second byte arrives while first is unread
    s_bytes[0] = 8'h11; s_bytes[1] = 8'h22; s_bytes[2] = 8'h33;
    wr_ctl(1'b0, 1'b0);
    pulse_start();
    wait_ready();
    repeat (40 * DIV) @(negedge clk);
    chk("R8 older byte kept", rx_data, 8'h11);
    chk("R8 scl held", scl_oe, 1);
    chk("R8 ready kept", rx_ready, 1);
    chk("R8 second byte at eighth clock", s_cnt, 1);
    wr_ctl(1'b1, 1'b0);
    clr_ready();
    wait_ready();
    chk("R8 second byte", rx_data, 8'h22);
    clr_ready();
    wait_ready();
    chk("R8 third byte", rx_data, 8'h33);
    clr_ready();
    wait_idle();
    chk("R10 count", s_cnt, 3);
    chk("R9 ack byte1", s_acks[1], 0);
    chk("R10 nack byte2", s_acks[2], 1);

    // stop request written mid-byte applies to the next byte
    s_bytes[0] = 8'h44; s_bytes[1] = 8'h55; s_bytes[2] = 8'h66;
    wr_ctl(1'b0, 1'b1);
    pulse_start();
    repeat (12) @(posedge scl_line);
    wr_ctl(1'b1, 1'b1);
    wait_ready();
    chk("R5 first", rx_data, 8'h44);
    clr_ready();
    wait_ready();
    chk("R5 second", rx_data, 8'h55);
    clr_ready();
    wait_idle();
    chk("R10 mid-byte request count", s_cnt, 2);
    chk("R9 ack first", s_acks[0], 0);
    chk("R10 nack second", s_acks[1], 1);

    // address not acknowledged
    slave_addr = 7'h12;
    wr_ctl(1'b0, 1'b0);
    pulse_start();
    wait_idle();
    chk("R12 no ready", rx_ready, 0);
    chk("R12 no data", s_cnt, 0);
    chk("R12 stop seen", stops, 1);
    chk("R12 lines released", {scl_line, sda_line}, 2'b11);

    finish_report();
  end

endmodule